// File: doc/BRIEF.md
# Single-Channel Bus-Mastering Block Mover

This block moves a block of bytes between one peripheral and system memory with no processor work per byte. Software loads a start address, a byte count, a direction and a holding mode while the block is idle, then pulses start. The block asks the processor for the system bus with a request line. It touches the memory port only while the processor's grant line is high. After the last byte it raises a one-cycle completion interrupt.

There are three holding modes. In burst mode the bus is kept for the whole block. In cycle-steal mode the bus is handed back after every byte, and a new request is made only once the peripheral has its next byte ready. In shared mode the request is held, but memory is accessed only in the slots that the processor leaves free. The `cpu_slot` input marks the slots the processor uses. Each clock cycle stands for one half-cycle of the shared bus.

Top module: `dma_xfer_ctrl`

## Requirements
- R1: `mem_en` and `per_ack` are high only while `bus_grant` is high, and `mem_en` is never high in a cycle unless `bus_req` was high in the cycle before.
- R2: Each rising edge of `bus_req` follows a cycle in which `bus_grant` was low, including the first request after a start.
- R3: The byte count falls by one and the address rises by one per byte moved. Byte k of a block uses memory address `start + k`, and the count never steps below zero.
- R4: With mode code 0 (burst; code 3 behaves the same), `bus_req` rises exactly once per block and stays high until the last byte.
- R5: With mode code 1 (cycle steal), at most one byte moves per grant period. `bus_req` is low in the cycle that byte completes, and a new request waits for `per_ready` high with `bus_grant` low.
- R6: With mode code 2 (shared), `mem_en` is high only in cycles where `cpu_slot` is low.
- R7: With direction 0 (peripheral to memory), each byte is one cycle in which `mem_en`, `mem_we` and `per_ack` are high together and `mem_wdata` equals `per_rdata`.
- R8: With direction 1 (memory to peripheral), a read (`mem_en` high, `mem_we` low) in cycle t is followed by `per_ack` in cycle t+1, with `per_wdata` equal to the memory's registered read data.
- R9: `done_irq` pulses for one cycle, in the cycle after the last byte completes, with `bus_req` low. The number of bytes moved equals the loaded count.
- R10: A start with a count of zero raises `done_irq` in the next cycle and never raises `bus_req`.
- R11: Configuration writes and start pulses made while a block is in progress have no effect on that block, and no new block begins after it.
- R12: During and just after reset, `bus_req`, `mem_en`, `per_ack` and `done_irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Load address, count, direction and mode |
| cfg_addr | input | AW | Start address |
| cfg_count | input | CW | Number of bytes |
| cfg_dir | input | 1 | 0 peripheral to memory, 1 memory to peripheral |
| cfg_mode | input | 2 | 0 burst, 1 cycle steal, 2 shared, 3 burst |
| cfg_start | input | 1 | Start pulse |
| bus_req | output | 1 | Request for the system bus |
| bus_grant | input | 1 | Processor has released the bus |
| cpu_slot | input | 1 | Processor owns the current slot (shared mode) |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write when high, read when low |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, one cycle after the read |
| per_ready | input | 1 | Peripheral holds a byte or has room for one |
| per_rdata | input | DW | Byte offered by the peripheral |
| per_ack | output | 1 | Byte taken from or given to the peripheral |
| per_wdata | output | DW | Byte handed to the peripheral |
| done_irq | output | 1 | Completion pulse |

## Verification
A wrong holding state shows up at once on `bus_req`. A request that stays high in steal mode, or that drops in mid-burst, is visible in the cycle the byte completes or in the cycle after it. A wrong count or address register shows up at the first byte that follows the error, as an address mismatch on the memory port. A count that is off by one also moves `done_irq` by at least one cycle, or changes the number of bytes moved. A direction or slot error is visible in the same cycle as a wrong `mem_we` or as an access in a processor-owned slot.

// File: rtl/dmx_pkg.sv
package dmx_pkg;

    typedef enum logic [1:0] {
        MD_BURST = 2'd0,
        MD_STEAL = 2'd1,
        MD_SHARE = 2'd2,
        MD_RSVD  = 2'd3
    } dmx_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_RELWAIT = 2'd1,
        ST_OWN     = 2'd2,
        ST_RDLAT   = 2'd3
    } dmx_state_e;

endpackage

// File: rtl/dmx_cfg_regs.sv
module dmx_cfg_regs
    import dmx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       idle,
    input  logic       dir_in,
    input  logic [1:0] mode_in,
    output logic       dir_q,
    output dmx_mode_e  mode_q
);

    typedef struct packed {
        logic      dir;
        dmx_mode_e mode;
    } cfg_t;

    cfg_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (wr_en && idle) begin
            nxt_d.dir  = dir_in;
            nxt_d.mode = dmx_mode_e'(mode_in);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '{dir: 1'b0, mode: MD_BURST};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign dir_q  = cur_q.dir;
    assign mode_q = cur_q.mode;

    AST_CFG_FROZEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !idle |=> $stable(cur_q)) else $error("cfg changed while busy"); // R11

endmodule

// File: rtl/dmx_datapath.sv
module dmx_datapath #(
    parameter int AW = 16,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] addr_in,
    input  logic [CW-1:0] count_in,
    input  logic          step,
    output logic [AW-1:0] addr_q,
    output logic          cnt_zero,
    output logic          cnt_last
);

    localparam logic [AW-1:0] ADDR_INC = AW'(1);
    localparam logic [CW-1:0] CNT_DEC  = CW'(1);

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [CW-1:0] cnt;
    } dp_t;

    dp_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (load) begin
            nxt_d.addr = addr_in;
            nxt_d.cnt  = count_in;
        end else if (step) begin
            nxt_d.addr = cur_q.addr + ADDR_INC;
            nxt_d.cnt  = cur_q.cnt - CNT_DEC;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign addr_q   = cur_q.addr;
    assign cnt_zero = (cur_q.cnt == '0);
    assign cnt_last = (cur_q.cnt == CNT_DEC);

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> !cnt_zero) else $error("count stepped at zero"); // R3

    AST_NO_LOAD_DURING_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> !load) else $error("load while moving"); // R11

endmodule

// File: rtl/dmx_seq.sv
module dmx_seq
    import dmx_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start,
    input  logic      cnt_zero,
    input  logic      cnt_last,
    input  logic      dir,
    input  dmx_mode_e mode,
    input  logic      bus_grant,
    input  logic      per_ready,
    input  logic      cpu_slot,
    output logic      idle,
    output logic      bus_req,
    output logic      mem_en,
    output logic      mem_we,
    output logic      per_ack,
    output logic      step,
    output logic      done_irq
);

    typedef struct packed {
        dmx_state_e st;
        logic       done;
    } seq_t;

    seq_t       cur_q, nxt_d;
    logic       go;
    logic       period_end;
    logic       steal_mode;
    dmx_state_e after_st;

    always_comb begin
        steal_mode = (mode == MD_STEAL);
        go         = bus_grant && per_ready && !((mode == MD_SHARE) && cpu_slot);
        period_end = cnt_last || steal_mode;
        if (cnt_last) begin
            after_st = ST_IDLE;
        end else if (steal_mode) begin
            after_st = ST_RELWAIT;
        end else begin
            after_st = ST_OWN;
        end

        nxt_d      = cur_q;
        nxt_d.done = 1'b0;
        bus_req    = 1'b0;
        mem_en     = 1'b0;
        mem_we     = 1'b0;
        per_ack    = 1'b0;
        step       = 1'b0;

        unique case (cur_q.st)
            ST_IDLE: begin
                if (start) begin
                    if (cnt_zero) begin
                        nxt_d.done = 1'b1;
                    end else begin
                        nxt_d.st = ST_RELWAIT;
                    end
                end
            end
            ST_RELWAIT: begin
                if (!bus_grant && (!steal_mode || per_ready)) begin
                    nxt_d.st = ST_OWN;
                end
            end
            ST_OWN: begin
                bus_req = 1'b1;
                if (go) begin
                    mem_en = 1'b1;
                    if (!dir) begin
                        mem_we     = 1'b1;
                        per_ack    = 1'b1;
                        step       = 1'b1;
                        bus_req    = !period_end;
                        nxt_d.st   = after_st;
                        nxt_d.done = cnt_last;
                    end else begin
                        nxt_d.st = ST_RDLAT;
                    end
                end
            end
            ST_RDLAT: begin
                per_ack    = 1'b1;
                step       = 1'b1;
                bus_req    = !period_end;
                nxt_d.st   = after_st;
                nxt_d.done = cnt_last;
            end
            default: nxt_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '{st: ST_IDLE, done: 1'b0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign idle     = (cur_q.st == ST_IDLE);
    assign done_irq = cur_q.done;

    AST_STEAL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (steal_mode && step) |=> !bus_req) else $error("steal kept bus"); // R5

    AST_REQ_AFTER_LOW_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_req) |-> !$past(bus_grant)) else $error("request while grant high"); // R2

    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq |-> (!bus_req && !mem_en)) else $error("done with bus active"); // R9

    AST_SHARE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == MD_SHARE) && mem_en) |-> !cpu_slot) else $error("slot clash"); // R6

    AST_READ_THEN_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && !mem_we) |=> per_ack) else $error("read not delivered"); // R8

endmodule

// File: rtl/dma_xfer_ctrl.sv
module dma_xfer_ctrl
    import dmx_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [AW-1:0] cfg_addr,
    input  logic [CW-1:0] cfg_count,
    input  logic          cfg_dir,
    input  logic [1:0]    cfg_mode,
    input  logic          cfg_start,
    output logic          bus_req,
    input  logic          bus_grant,
    input  logic          cpu_slot,
    output logic          mem_en,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          per_ready,
    input  logic [DW-1:0] per_rdata,
    output logic          per_ack,
    output logic [DW-1:0] per_wdata,
    output logic          done_irq
);

    logic      idle;
    logic      dir_q;
    dmx_mode_e mode_q;
    logic      cnt_zero;
    logic      cnt_last;
    logic      step;

    dmx_cfg_regs u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .idle    (idle),
        .dir_in  (cfg_dir),
        .mode_in (cfg_mode),
        .dir_q   (dir_q),
        .mode_q  (mode_q)
    );

    dmx_datapath #(.AW(AW), .CW(CW)) u_dp (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cfg_we && idle),
        .addr_in  (cfg_addr),
        .count_in (cfg_count),
        .step     (step),
        .addr_q   (mem_addr),
        .cnt_zero (cnt_zero),
        .cnt_last (cnt_last)
    );

    dmx_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (cfg_start),
        .cnt_zero  (cnt_zero),
        .cnt_last  (cnt_last),
        .dir       (dir_q),
        .mode      (mode_q),
        .bus_grant (bus_grant),
        .per_ready (per_ready),
        .cpu_slot  (cpu_slot),
        .idle      (idle),
        .bus_req   (bus_req),
        .mem_en    (mem_en),
        .mem_we    (mem_we),
        .per_ack   (per_ack),
        .step      (step),
        .done_irq  (done_irq)
    );

    assign mem_wdata = per_rdata;
    assign per_wdata = mem_rdata;

    AST_MEM_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |-> $past(bus_req)) else $error("memory used without request"); // R1

    AST_WRITE_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && mem_we) |-> per_ack) else $error("write without peripheral ack"); // R7

endmodule

// File: tb/sim_dma_xfer_ctrl.sv
module sim_dma_xfer_ctrl;

    localparam int AW = 16;
    localparam int CW = 8;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [AW-1:0] cfg_addr = '0;
    logic [CW-1:0] cfg_count = '0;
    logic          cfg_dir = 1'b0;
    logic [1:0]    cfg_mode = 2'd0;
    logic          cfg_start = 1'b0;
    logic          bus_req;
    logic          bus_grant = 1'b0;
    logic          cpu_slot = 1'b0;
    logic          mem_en, mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata = '0;
    logic          per_ready = 1'b0;
    logic [DW-1:0] per_rdata;
    logic          per_ack;
    logic [DW-1:0] per_wdata;
    logic          done_irq;

    int tests = 0;
    int fails = 0;
    int cyc = 0;

    int blk_id = 0, blk_base = 0, blk_cnt = 0, blk_dir = 0, blk_mode = 0;
    int rdy_sel = 0, start_cyc = 0, done_seen = 0, p_idx = 0;

    logic [7:0] mem [256];

    dma_xfer_ctrl #(.AW(AW), .CW(CW), .DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_count(cfg_count), .cfg_dir(cfg_dir), .cfg_mode(cfg_mode),
        .cfg_start(cfg_start), .bus_req(bus_req), .bus_grant(bus_grant),
        .cpu_slot(cpu_slot), .mem_en(mem_en), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .per_ready(per_ready), .per_rdata(per_rdata), .per_ack(per_ack),
        .per_wdata(per_wdata), .done_irq(done_irq)
    );

    always #4 clk = ~clk;

    function automatic logic [7:0] pat(int a);
        return 8'((a * 7 + 3) & 255);
    endfunction

    function automatic logic [7:0] src(int i);
        return 8'((i * 13 + 90) & 255);
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d at cycle %0d", req, what, act, exp, cyc);
        end
    endtask

    // processor, memory and peripheral models
    always @(posedge clk) begin
        cyc       <= cyc + 1;
        bus_grant <= rst_n ? bus_req : 1'b0;
        cpu_slot  <= ~cpu_slot;
        per_ready <= (rdy_sel == 0) ? 1'b1 : ((cyc % 3) != 0);
        if (mem_en) begin
            if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
            else        mem_rdata <= mem[mem_addr[7:0]];
        end
        if (per_ack && mem_we) p_idx <= p_idx + 1;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    assign per_rdata = src(p_idx);

    // reference checker, sampled away from the active edge
    int  seen_blk = 0, xfer_n = 0, rises = 0, in_grant = 0, last_ack = 0, exp_src = 0;
    bit  rd_pend = 0, prev_req = 0, prev_grant = 0, prev_done = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (blk_id != seen_blk) begin
                seen_blk = blk_id; xfer_n = 0; rises = 0; in_grant = 0;
            end
            if (!bus_grant) in_grant = 0;
            if (mem_en) begin
                chk(bus_grant, "R1", "mem_en without grant", 0, 1);
                chk(prev_req, "R1", "mem_en without prior request", 0, 1);
                chk(int'(mem_addr) == blk_base + xfer_n, "R3", "address", int'(mem_addr), blk_base + xfer_n);
                chk(mem_we == (blk_dir == 0), "R7", "write strobe vs direction", int'(mem_we), int'(blk_dir == 0));
            end
            if (blk_mode == 2 && mem_en) chk(!cpu_slot, "R6", "access in processor slot", 1, 0);
            if (bus_req && !prev_req) begin
                rises++;
                chk(!prev_grant, "R2", "request while grant high", 1, 0);
            end
            if (mem_en && mem_we) begin
                chk(mem_wdata == src(exp_src), "R7", "write data", int'(mem_wdata), int'(src(exp_src)));
                chk(per_ack, "R7", "ack with write", 0, 1);
                exp_src++;
            end
            if (per_ack) begin
                chk(bus_grant, "R1", "ack without grant", 0, 1);
                if (blk_dir == 1) begin
                    chk(rd_pend, "R8", "ack without read one cycle earlier", 0, 1);
                    chk(per_wdata == pat(blk_base + xfer_n), "R8", "read data", int'(per_wdata), int'(pat(blk_base + xfer_n)));
                end
                in_grant++;
                if (blk_mode == 1) begin
                    chk(!bus_req, "R5", "request still high at steal completion", 1, 0);
                    chk(in_grant <= 1, "R5", "bytes in one grant", in_grant, 1);
                end
                if (blk_mode == 0 && xfer_n + 1 < blk_cnt)
                    chk(bus_req, "R4", "burst request dropped mid-block", 0, 1);
                last_ack = cyc;
                xfer_n++;
            end
            if (done_irq) begin
                chk(!prev_done, "R9", "done longer than one cycle", 1, 0);
                chk(!bus_req, "R9", "request during done", 1, 0);
                chk(xfer_n == blk_cnt, "R9", "bytes moved", xfer_n, blk_cnt);
                if (blk_cnt > 0) begin
                    chk(cyc == last_ack + 1, "R9", "done cycle", cyc, last_ack + 1);
                    if (blk_mode == 0 || blk_mode == 3) chk(rises == 1, "R4", "request rises in burst", rises, 1);
                    if (blk_mode == 1) chk(rises == blk_cnt, "R5", "request rises in steal", rises, blk_cnt);
                end else begin
                    chk(cyc == start_cyc + 1, "R10", "zero-count done cycle", cyc, start_cyc + 1);
                    chk(rises == 0, "R10", "request on zero count", rises, 0);
                end
                done_seen++;
            end
        end
        rd_pend    = mem_en && !mem_we;
        prev_req   = bus_req;
        prev_grant = bus_grant;
        prev_done  = done_irq;
    end

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic run_block(int base, int cnt, int dir, int md, int rdy, bit disturb);
        int d0;
        tick();
        blk_base = base; blk_cnt = cnt; blk_dir = dir; blk_mode = md; rdy_sel = rdy;
        blk_id++;
        cfg_we = 1'b1; cfg_addr = AW'(base); cfg_count = CW'(cnt);
        cfg_dir = dir[0]; cfg_mode = md[1:0];
        tick();
        cfg_we = 1'b0; cfg_start = 1'b1; start_cyc = cyc; d0 = done_seen;
        tick();
        cfg_start = 1'b0;
        if (disturb) begin
            repeat (3) tick();
            cfg_we = 1'b1; cfg_addr = 16'h00EE; cfg_count = 8'd99;
            cfg_dir = ~dir[0]; cfg_mode = 2'd1; cfg_start = 1'b1;
            tick();
            cfg_we = 1'b0; cfg_start = 1'b0;
        end
        for (int k = 0; k < 3000 && done_seen == d0; k++) tick();
        chk(done_seen == d0 + 1, "R9", "block completion seen", done_seen - d0, 1);
        repeat (4) tick();
    endtask

    initial begin
        for (int a = 0; a < 256; a++) mem[a] = pat(a);
        repeat (3) tick();
        chk(!bus_req && !mem_en && !per_ack && !done_irq, "R12", "outputs in reset", 1, 0);
        rst_n = 1'b1;
        tick();
        chk(!bus_req && !mem_en && !per_ack && !done_irq, "R12", "outputs after reset", 1, 0);

        run_block(8'h20, 0, 0, 0, 0, 1'b0);            // R10 zero count
        run_block(8'h10, 5, 0, 0, 0, 1'b0);            // R4 R7 burst in
        run_block(8'h18, 6, 0, 0, 1, 1'b0);            // R4 burst with peripheral gaps
        run_block(8'h30, 4, 0, 1, 0, 1'b0);            // R5 steal in
        run_block(8'h38, 5, 0, 1, 1, 1'b0);            // R5 steal with gaps
        run_block(8'h40, 6, 0, 2, 0, 1'b0);            // R6 shared in
        run_block(8'hA0, 4, 1, 0, 0, 1'b0);            // R8 burst out
        run_block(8'hA8, 3, 1, 1, 1, 1'b0);            // R8 R5 steal out
        run_block(8'hB0, 5, 1, 2, 0, 1'b0);            // R8 R6 shared out
        run_block(8'h50, 3, 0, 3, 0, 1'b0);            // R4 code 3 acts as burst
        run_block(8'h60, 8, 0, 0, 1, 1'b1);            // R11 writes while busy

        for (int k = 0; k < 12; k++) begin
            tick();
            chk(!bus_req, "R11", "new request after ignored start", 1, 0);
        end
        run_block(8'hC0, 1, 1, 0, 0, 1'b0);            // R3 single byte

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule